// File: doc/BRIEF.md
# Serial Cache-Line Download Decoder

This block sits in the test-clock domain behind a debug access port. While the instruction that loads code into the instruction cache is selected, a host scans fixed 33-bit packets into a data register, one packet per update. The decoder turns the packets into cache commands. A packet in the command slot carries a 3-bit opcode and a line address. The opcode asks for one line to be invalidated, for the whole mini cache to be invalidated, or for a full line to be loaded into the main or the mini cache.

A load command is followed by exactly eight data packets. Each carries one 32-bit instruction word and an even-parity bit. Every good word appears on a simple write port with its index within the line. A word with a parity mismatch is dropped, and a sticky error flag is raised. Leaving the load instruction or a test-logic reset abandons any line in progress, and the next packet is then read as a command.

Top module: `cline_dl_decoder`

## Requirements
- R1: While `ld_sel` and `shift_dr` are high at a rising `tck` edge, `tdi` is shifted in, and the first bit shifted lands at packet bit 0 of the 33 bits. A rising edge with `update_dr` and `ld_sel` high ends the packet. Any resulting strobe is high for exactly the one cycle after that edge.
- R2: In the command slot, bits [2:0] hold the opcode and bits [32:6] hold the line address, which is presented on `cmd_addr`. Bits [5:3] are ignored. Opcode 000 (invalidate one line) and opcode 001 (invalidate the whole mini cache) each give one `cmd_valid` strobe with `cmd_op` equal to the opcode.
- R3: Opcode 010 (load a main-cache line) and opcode 011 (load a mini-cache line) each give one `cmd_valid` strobe. The next eight packets are then data words 0 to 7 of that line, reported on `wr_idx`. `wr_mini` is 1 for a mini-cache line and 0 for a main-cache line. `cmd_valid` and `wr_valid` are never high together.
- R4: A data packet holds the parity bit at bit 0 and the word at bits [32:1]. When the parity bit equals the XOR of the 32 word bits (even parity), the packet gives a `wr_valid` strobe carrying that word.
- R5: A data packet with a parity mismatch gives no `wr_valid` strobe, but it still uses up its word slot. `parity_err` goes high in the cycle after that packet and stays high until reset.
- R6: Opcodes 100 to 111 give no strobe, and the packet that follows is still read as a command.
- R7: After the eighth data packet of a line, the next packet is read as a command.
- R8: While `ld_sel` is low, shifts and updates have no effect. Dropping `ld_sel` during a line abandons the line, so the first packet after `ld_sel` returns is read as a command.
- R9: While `trst_n` is low, `cmd_valid`, `wr_valid` and `parity_err` are 0 and any line in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test-logic reset, active low, asynchronous |
| ld_sel | input | 1 | Cache-load instruction is selected |
| shift_dr | input | 1 | Data-register shift state |
| update_dr | input | 1 | Data-register update state, ends a packet |
| tdi | input | 1 | Serial data in |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_op | output | 3 | Opcode of the command |
| cmd_addr | output | 27 | Line address of the command |
| wr_valid | output | 1 | One-cycle word write strobe |
| wr_mini | output | 1 | Write targets the mini cache |
| wr_idx | output | 3 | Word index within the line |
| wr_data | output | 32 | Instruction word |
| parity_err | output | 1 | Sticky parity-mismatch flag |

## Verification
On every cycle, the assertions check the following. A strobe only ever follows a selected update. Command and write strobes never coincide. A reported opcode is always one of the four defined ones. The parity flag never falls outside reset, and no write appears in the cycle the flag rises. Only the bench's scenarios can show the rest: that the address and data bits are taken from the right packet positions, that the word slots are counted across a line (including one with a corrupted word), and that an unknown opcode, a full line, a dropped select or a reset each bring the decoder back to reading a command.

// File: rtl/cdl_pkg.sv
package cdl_pkg;
    localparam int CMD_W    = 3;
    localparam int ADDR_LSB = 6;

    typedef enum logic [CMD_W-1:0] {
        OP_INV_LINE = 3'b000,
        OP_INV_MINI = 3'b001,
        OP_LD_MAIN  = 3'b010,
        OP_LD_MINI  = 3'b011
    } op_e;

    typedef enum logic {
        ST_CMD  = 1'b0,
        ST_DATA = 1'b1
    } st_e;
endpackage

// File: rtl/cdl_shift.sv
module cdl_shift #(
    parameter int PKT_W = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             sin,
    output logic [PKT_W-1:0] pkt
);
    logic [PKT_W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (shift_en) begin
            sr_d = {sin, sr_q[PKT_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign pkt = sr_q;
endmodule

// File: rtl/cdl_seq.sv
module cdl_seq
    import cdl_pkg::*;
#(
    parameter int PKT_W      = 33,
    parameter int LINE_WORDS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sel,
    input  logic                          upd,
    input  logic [PKT_W-1:0]              pkt,
    output logic                          cmd_valid,
    output logic [CMD_W-1:0]              cmd_op,
    output logic [PKT_W-ADDR_LSB-1:0]     cmd_addr,
    output logic                          wr_valid,
    output logic                          wr_mini,
    output logic [$clog2(LINE_WORDS)-1:0] wr_idx,
    output logic [PKT_W-2:0]              wr_data,
    output logic                          parity_err
);
    localparam int WORD_W = PKT_W - 1;
    localparam int ADDR_W = PKT_W - ADDR_LSB;
    localparam int IDX_W  = $clog2(LINE_WORDS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(LINE_WORDS - 1);

    typedef struct packed {
        st_e               st;
        logic [IDX_W-1:0]  cnt;
        logic              mini;
        logic              cmd_valid;
        logic [CMD_W-1:0]  cmd_op;
        logic [ADDR_W-1:0] cmd_addr;
        logic              wr_valid;
        logic              wr_mini;
        logic [IDX_W-1:0]  wr_idx;
        logic [WORD_W-1:0] wr_data;
        logic              perr;
    } state_t;

    state_t d, q;
    logic [CMD_W-1:0] op;
    logic             par_bad;

    always_comb begin
        d          = q;
        d.cmd_valid = 1'b0;
        d.wr_valid  = 1'b0;
        op         = pkt[CMD_W-1:0];
        par_bad    = ^pkt;
        if (!sel) begin
            d.st  = ST_CMD;
            d.cnt = '0;
        end else if (upd) begin
            if (q.st == ST_CMD) begin
                if (op[2] == 1'b0) begin
                    d.cmd_valid = 1'b1;
                    d.cmd_op    = op;
                    d.cmd_addr  = pkt[PKT_W-1:ADDR_LSB];
                    if (op[1]) begin
                        d.st   = ST_DATA;
                        d.cnt  = '0;
                        d.mini = op[0];
                    end
                end
            end else begin
                if (par_bad) begin
                    d.perr = 1'b1;
                end else begin
                    d.wr_valid = 1'b1;
                    d.wr_mini  = q.mini;
                    d.wr_idx   = q.cnt;
                    d.wr_data  = pkt[PKT_W-1:1];
                end
                if (q.cnt == LAST) begin
                    d.st  = ST_CMD;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + IDX_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_CMD, default: '0};
        end else begin
            q <= d;
        end
    end

    assign cmd_valid  = q.cmd_valid;
    assign cmd_op     = q.cmd_op;
    assign cmd_addr   = q.cmd_addr;
    assign wr_valid   = q.wr_valid;
    assign wr_mini    = q.wr_mini;
    assign wr_idx     = q.wr_idx;
    assign wr_data    = q.wr_data;
    assign parity_err = q.perr;
endmodule

// File: rtl/cline_dl_decoder.sv
module cline_dl_decoder
    import cdl_pkg::*;
#(
    parameter int PKT_W      = 33,
    parameter int LINE_WORDS = 8
) (
    input  logic                          tck,
    input  logic                          trst_n,
    input  logic                          ld_sel,
    input  logic                          shift_dr,
    input  logic                          update_dr,
    input  logic                          tdi,
    output logic                          cmd_valid,
    output logic [CMD_W-1:0]              cmd_op,
    output logic [PKT_W-ADDR_LSB-1:0]     cmd_addr,
    output logic                          wr_valid,
    output logic                          wr_mini,
    output logic [$clog2(LINE_WORDS)-1:0] wr_idx,
    output logic [PKT_W-2:0]              wr_data,
    output logic                          parity_err
);
    logic [PKT_W-1:0] pkt;

    cdl_shift #(.PKT_W(PKT_W)) u_shift (
        .clk      (tck),
        .rst_n    (trst_n),
        .shift_en (ld_sel & shift_dr),
        .sin      (tdi),
        .pkt      (pkt)
    );

    cdl_seq #(.PKT_W(PKT_W), .LINE_WORDS(LINE_WORDS)) u_seq (
        .clk        (tck),
        .rst_n      (trst_n),
        .sel        (ld_sel),
        .upd        (update_dr),
        .pkt        (pkt),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_addr   (cmd_addr),
        .wr_valid   (wr_valid),
        .wr_mini    (wr_mini),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .parity_err (parity_err)
    );
endmodule

// File: rtl/cline_dl_checker.sv
module cline_dl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sel_ld,
    input logic       upd,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       wr_valid,
    input logic       parity_err
);
    AST_STROBE_AFTER_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid || wr_valid) |-> $past(upd && sel_ld)); // R1

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && wr_valid)); // R3

    AST_KNOWN_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_op[2] == 1'b0)); // R6

    AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(parity_err) |-> parity_err); // R5

    AST_PERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(parity_err) |-> !wr_valid); // R5

    AST_SEL_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sel_ld) |-> (!cmd_valid && !wr_valid)); // R8
endmodule

bind cline_dl_decoder cline_dl_checker u_chk (
    .clk        (tck),
    .rst_n      (trst_n),
    .sel_ld     (ld_sel),
    .upd        (update_dr),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .wr_valid   (wr_valid),
    .parity_err (parity_err)
);

// File: tb/tb_cline_dl_decoder.sv
module tb_cline_dl_decoder;
    logic        tck = 1'b0;
    logic        trst_n = 1'b0;
    logic        ld_sel = 1'b0;
    logic        shift_dr = 1'b0;
    logic        update_dr = 1'b0;
    logic        tdi = 1'b0;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [26:0] cmd_addr;
    logic        wr_valid;
    logic        wr_mini;
    logic [2:0]  wr_idx;
    logic [31:0] wr_data;
    logic        parity_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    cline_dl_decoder dut (
        .tck(tck), .trst_n(trst_n), .ld_sel(ld_sel), .shift_dr(shift_dr),
        .update_dr(update_dr), .tdi(tdi), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .wr_valid(wr_valid), .wr_mini(wr_mini),
        .wr_idx(wr_idx), .wr_data(wr_data), .parity_err(parity_err)
    );

    always #10 tck = ~tck;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Scan 33 bits, bit 0 first, then one update; returns at the negedge
    // after the update edge, when the registered strobes are visible.
    task automatic send(input logic [32:0] p);
        for (int i = 0; i < 33; i++) begin
            @(negedge tck);
            shift_dr = 1'b1;
            tdi      = p[i];
        end
        @(negedge tck);
        shift_dr  = 1'b0;
        update_dr = 1'b1;
        @(negedge tck);
        update_dr = 1'b0;
    endtask

    function automatic logic [32:0] mk_cmd(input logic [2:0] op, input logic [26:0] a);
        return {a, 3'b101, op};
    endfunction

    function automatic logic [32:0] mk_data(input logic [31:0] w, input logic bad);
        return {w, (^w) ^ bad};
    endfunction

    function automatic logic [31:0] word_of(input int ln, input int i);
        return (32'(ln * 8 + i + 1) * 32'h9E3779B9) ^ 32'(ln << 4);
    endfunction

    task automatic exp_none(input string req);
        chk(req, "cmd_valid", 32'(cmd_valid), 0);
        chk(req, "wr_valid", 32'(wr_valid), 0);
    endtask

    task automatic exp_cmd(input string req, input logic [2:0] op, input logic [26:0] a);
        chk(req, "cmd_valid", 32'(cmd_valid), 1);
        chk(req, "wr_valid", 32'(wr_valid), 0);
        chk(req, "cmd_op", 32'(cmd_op), 32'(op));
        chk(req, "cmd_addr", 32'(cmd_addr), 32'(a));
    endtask

    task automatic exp_wr(input string req, input int idx, input logic mini, input logic [31:0] w);
        chk(req, "wr_valid", 32'(wr_valid), 1);
        chk(req, "cmd_valid", 32'(cmd_valid), 0);
        chk(req, "wr_idx", 32'(wr_idx), 32'(idx));
        chk(req, "wr_mini", 32'(wr_mini), 32'(mini));
        chk(req, "wr_data", wr_data, w);
    endtask

    initial begin
        repeat (3) @(negedge tck);
        // R9: reset state
        exp_none("R9");
        chk("R9", "parity_err", 32'(parity_err), 0);
        trst_n = 1'b1;
        ld_sel = 1'b1;
        @(negedge tck);

        // R2, R6: sweep all opcodes with several addresses
        for (int a = 0; a < 4; a++) begin
            for (int op = 0; op < 8; op++) begin
                logic [26:0] addr;
                addr = 27'(a * 27'h2A5_B3C1 + op * 27'h111 + 1);
                if (op == 2 || op == 3) continue;
                send(mk_cmd(3'(op), addr));
                if (op < 2) begin
                    exp_cmd("R2", 3'(op), addr);
                    @(negedge tck);
                    exp_none("R1");
                end else begin
                    exp_none("R6");
                    // next packet must still be a command
                    send(mk_cmd(3'b000, ~addr));
                    exp_cmd("R6", 3'b000, ~addr);
                end
            end
        end

        // R3, R4, R7: full lines to both caches
        for (int ln = 0; ln < 6; ln++) begin
            logic [26:0] addr;
            logic        mini;
            addr = 27'(ln * 27'h0ABCDE + 27'h40);
            mini = ln[0];
            send(mk_cmd({2'b01, mini}, addr));
            exp_cmd("R3", {2'b01, mini}, addr);
            for (int i = 0; i < 8; i++) begin
                send(mk_data(word_of(ln, i), 1'b0));
                exp_wr("R4", i, mini, word_of(ln, i));
            end
            // R7: a data-looking packet after eight words is a command
            send(mk_cmd(3'b001, addr ^ 27'h7));
            exp_cmd("R7", 3'b001, addr ^ 27'h7);
        end
        chk("R4", "parity_err", 32'(parity_err), 0);

        // R5: corrupted word 3 is dropped, the rest keep their slots
        send(mk_cmd(3'b010, 27'h155));
        exp_cmd("R3", 3'b010, 27'h155);
        for (int i = 0; i < 8; i++) begin
            send(mk_data(word_of(9, i), i == 3));
            if (i == 3) begin
                exp_none("R5");
                chk("R5", "parity_err", 32'(parity_err), 1);
            end else begin
                exp_wr("R5", i, 1'b0, word_of(9, i));
            end
        end
        send(mk_cmd(3'b000, 27'h3));
        exp_cmd("R5", 3'b000, 27'h3);
        chk("R5", "parity_err sticky", 32'(parity_err), 1);

        // R8: drop select mid-line; packets while deselected are ignored
        send(mk_cmd(3'b011, 27'h777));
        exp_cmd("R8", 3'b011, 27'h777);
        send(mk_data(word_of(10, 0), 1'b0));
        exp_wr("R8", 0, 1'b1, word_of(10, 0));
        ld_sel = 1'b0;
        send(mk_cmd(3'b001, 27'h1));
        exp_none("R8");
        ld_sel = 1'b1;
        send(mk_cmd(3'b000, 27'h5A5A));
        exp_cmd("R8", 3'b000, 27'h5A5A);

        // R9: reset mid-line clears the flag and abandons the line
        send(mk_cmd(3'b010, 27'h999));
        exp_cmd("R9", 3'b010, 27'h999);
        send(mk_data(word_of(11, 0), 1'b0));
        @(negedge tck);
        trst_n = 1'b0;
        @(negedge tck);
        exp_none("R9");
        chk("R9", "parity_err", 32'(parity_err), 0);
        trst_n = 1'b1;
        send(mk_cmd(3'b001, 27'h42));
        exp_cmd("R9", 3'b001, 27'h42);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge tck);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule